// File: doc/BRIEF.md
# Quad-Table Pattern and Edge Trigger

This block watches a bus of sixteen logic channels, one sample per valid strobe, and raises a trigger when a programmed condition holds. The channels form four groups of four. Each group addresses its own 16-entry truth table with its four channel bits. A value/mask pattern over the whole bus therefore needs one lookup per group and an AND of the four results. Two further table sets pick out up to two watched pins. Each of them is looked up with both the current sample and the previous sample. The four resulting bits address a 16-entry glue table, which turns them into an edge condition: rising, falling, or an OR of two such conditions.

Software compiles a condition into table rows. Each row carries one bit of every table. A row is first staged and then committed by a select write whose code names the row. A fast mode skips the tables and fires on a single edge of one pin among the low eight channels. Once the trigger fires it stays registered high until the block is armed again. A separate pin can mirror it.

The controller has four states. S_IDLE waits for arm. S_PRIME takes the first valid sample only as the previous sample. S_WATCH evaluates every valid sample. S_FIRED holds the trigger. Its transitions are as follows:
- arm moves any state to S_PRIME.
- A valid sample moves S_PRIME to S_WATCH.
- A valid sample that meets the condition moves S_WATCH to S_FIRED.

Top module: `qlut_trigger`

## Requirements
- R1: After reset, trig and trig_pin are 0, the block is in S_IDLE and every table entry is 0. As a result, arming with no rows loaded never fires.
- R2: A write on cfg_row_we stages cfg_row_data. A later cfg_sel_we with cfg_sel[7:4] = 4'h3 commits the staged row to row index cfg_sel[3:0]. In a row, bit g (0..3) is the value table of group g, bit 4+g is edge table 0 of group g, bit 8+g is edge table 1 of group g, and bit 12 is the glue entry.
- R3: A select write whose upper nibble is not 4'h3 changes no table entry.
- R4: In table mode, a valid sample meets the value condition when, for every group g, the value table entry is 1. Group g holds channels 4g..4g+3, and channel 4g is the least significant bit of the index.
- R5: Edge unit k yields a current bit (the AND of its four group entries indexed by the current sample) and a previous bit (the same, indexed by the previous valid sample). The glue table is addressed by {prev1, cur1, prev0, cur0}. In table mode the trigger condition is the value condition AND the addressed glue entry.
- R6: The first valid sample after arm only loads the previous-sample register and never fires.
- R7: trig rises one clock after the edge that takes a qualifying valid sample. It then stays high whatever the later samples are. Cycles with samp_valid low are ignored.
- R8: A one-cycle arm pulse clears trig on the following clock and restarts at S_PRIME.
- R9: With fast_en high the tables are ignored. The condition is an edge on channel fast_sel[2:0], rising when fast_sel[3] is 0 and falling when it is 1.
- R10: trig_pin follows trig when trig_out_en is 1 and is 0 otherwise.
- R11: Without arm after reset (S_IDLE), no sample fires the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and configuration clock |
| rst_n | input | 1 | Active-low reset |
| samp_valid | input | 1 | A sample is present this cycle |
| samp | input | 16 | Channel values |
| cfg_row_we | input | 1 | Stage cfg_row_data |
| cfg_row_data | input | 13 | Row bits: value, edge 0, edge 1 tables and glue |
| cfg_sel_we | input | 1 | Select write strobe |
| cfg_sel | input | 8 | Select code; 0x30 plus row index commits a row |
| fast_en | input | 1 | Single-pin edge mode |
| fast_sel | input | 4 | Pin index [2:0], falling flag [3] |
| trig_out_en | input | 1 | Enables trig_pin |
| arm | input | 1 | Re-arm pulse |
| trig | output | 1 | Registered, sticky trigger |
| trig_pin | output | 1 | Trigger-out pin |

## Verification
The assertions take arm to be a single-cycle pulse, issued in a cycle that carries no valid sample. They also take fast_en and fast_sel to be steady around every evaluated sample, so that the edge recorded on the fast pin belongs to the settings that were in force. The directed tasks drive every input on the falling clock edge and pulse arm on its own. They change the mode fields only before arming, and configuration writes never overlap a live sample.

// File: rtl/qlut_pkg.sv
package qlut_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PRIME = 2'd1,
        S_WATCH = 2'd2,
        S_FIRED = 2'd3
    } trig_state_t;

    localparam logic [3:0] ROW_COMMIT_CODE = 4'h3;
    localparam int         GLUE_DEPTH      = 16;
endpackage

// File: rtl/qlut_store.sv
module qlut_store #(
    parameter int GROUPS = 4,
    parameter int GW     = 4,
    parameter int SEL_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        row_we,
    input  logic [3*GROUPS:0]           row_data,
    input  logic                        sel_we,
    input  logic [SEL_W-1:0]            sel,
    output logic [GROUPS*(1<<GW)-1:0]   val_tab,
    output logic [GROUPS*(1<<GW)-1:0]   e0_tab,
    output logic [GROUPS*(1<<GW)-1:0]   e1_tab,
    output logic [qlut_pkg::GLUE_DEPTH-1:0] glue_tab
);
    import qlut_pkg::*;

    localparam int DEPTH = 1 << GW;
    localparam int ROW_W = 3 * GROUPS + 1;

    logic [ROW_W-1:0] stage_q;
    logic [GW-1:0]    row_idx;
    logic             commit;

    assign row_idx = sel[GW-1:0];
    assign commit  = sel_we && (sel[SEL_W-1:SEL_W-4] == ROW_COMMIT_CODE);

    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (row_we)
            stage_q <= row_data;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [DEPTH-1:0] val_q, e0_q, e1_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                e0_q  <= '0;
                e1_q  <= '0;
            end else if (commit) begin
                val_q[row_idx] <= stage_q[g];
                e0_q[row_idx]  <= stage_q[GROUPS + g];
                e1_q[row_idx]  <= stage_q[2*GROUPS + g];
            end
        end
        assign val_tab[g*DEPTH +: DEPTH] = val_q;
        assign e0_tab[g*DEPTH +: DEPTH]  = e0_q;
        assign e1_tab[g*DEPTH +: DEPTH]  = e1_q;
    end

    logic [GLUE_DEPTH-1:0] glue_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            glue_q <= '0;
        else if (commit && (int'(row_idx) < GLUE_DEPTH))
            glue_q[4'(row_idx)] <= stage_q[3*GROUPS];
    end
    assign glue_tab = glue_q;
endmodule

// File: rtl/qlut_match.sv
module qlut_match #(
    parameter int GROUPS = 4,
    parameter int GW     = 4
) (
    input  logic [GROUPS*(1<<GW)-1:0] tab,
    input  logic [GROUPS*GW-1:0]      data,
    output logic                      hit
);
    localparam int DEPTH = 1 << GW;

    logic [GROUPS-1:0] grp_hit;

    for (genvar g = 0; g < GROUPS; g++) begin : g_look
        logic [DEPTH-1:0] t;
        assign t          = tab[g*DEPTH +: DEPTH];
        assign grp_hit[g] = t[data[g*GW +: GW]];
    end

    assign hit = &grp_hit;
endmodule

// File: rtl/qlut_trigger.sv
module qlut_trigger #(
    parameter int GROUPS     = 4,
    parameter int GW         = 4,
    parameter int SEL_W      = 8,
    parameter int FAST_IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_valid,
    input  logic [GROUPS*GW-1:0]     samp,
    input  logic                     cfg_row_we,
    input  logic [3*GROUPS:0]        cfg_row_data,
    input  logic                     cfg_sel_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic                     fast_en,
    input  logic [FAST_IDX_W:0]      fast_sel,
    input  logic                     trig_out_en,
    input  logic                     arm,
    output logic                     trig,
    output logic                     trig_pin
);
    import qlut_pkg::*;

    localparam int CH    = GROUPS * GW;
    localparam int DEPTH = 1 << GW;

    trig_state_t state_q, state_d;

    logic [CH-1:0]             prev_q;
    logic [GROUPS*DEPTH-1:0]   val_tab, e0_tab, e1_tab;
    logic [GLUE_DEPTH-1:0]     glue_tab;
    logic                      val_hit;
    logic [1:0]                cur_hit, old_hit;
    logic [3:0]                glue_idx;
    logic                      fast_hit, cond;

    qlut_store #(.GROUPS(GROUPS), .GW(GW), .SEL_W(SEL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_we   (cfg_row_we),
        .row_data (cfg_row_data),
        .sel_we   (cfg_sel_we),
        .sel      (cfg_sel),
        .val_tab  (val_tab),
        .e0_tab   (e0_tab),
        .e1_tab   (e1_tab),
        .glue_tab (glue_tab)
    );

    qlut_match #(.GROUPS(GROUPS), .GW(GW)) u_val (
        .tab  (val_tab),
        .data (samp),
        .hit  (val_hit)
    );

    for (genvar k = 0; k < 2; k++) begin : g_edge
        logic [GROUPS*DEPTH-1:0] etab;
        assign etab = (k == 0) ? e0_tab : e1_tab;

        qlut_match #(.GROUPS(GROUPS), .GW(GW)) u_cur (
            .tab  (etab),
            .data (samp),
            .hit  (cur_hit[k])
        );
        qlut_match #(.GROUPS(GROUPS), .GW(GW)) u_old (
            .tab  (etab),
            .data (prev_q),
            .hit  (old_hit[k])
        );
    end

    assign glue_idx = {old_hit[1], cur_hit[1], old_hit[0], cur_hit[0]};

    always_comb begin
        logic cur_b, old_b;
        cur_b    = samp[fast_sel[FAST_IDX_W-1:0]];
        old_b    = prev_q[fast_sel[FAST_IDX_W-1:0]];
        fast_hit = fast_sel[FAST_IDX_W] ? (old_b && !cur_b) : (!old_b && cur_b);
        cond     = fast_en ? fast_hit : (val_hit && glue_tab[glue_idx]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (arm) state_d = S_PRIME;
            S_PRIME: begin
                if (arm)             state_d = S_PRIME;
                else if (samp_valid) state_d = S_WATCH;
            end
            S_WATCH: begin
                if (arm)                     state_d = S_PRIME;
                else if (samp_valid && cond) state_d = S_FIRED;
            end
            S_FIRED: if (arm) state_d = S_PRIME;
            default: state_d = S_IDLE;
        endcase
    end

    // previous-sample register
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else if (samp_valid && !arm && (state_q == S_PRIME || state_q == S_WATCH))
            prev_q <= samp;
    end

    // outputs
    always_comb begin
        trig     = (state_q == S_FIRED);
        trig_pin = trig && trig_out_en;
    end
endmodule

// File: rtl/qlut_trigger_chk.sv
module qlut_trigger_chk #(
    parameter int CH  = 16,
    parameter int FIW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          samp_valid,
    input logic [CH-1:0] samp,
    input logic          fast_en,
    input logic [FIW:0]  fast_sel,
    input logic          trig_out_en,
    input logic          arm,
    input logic          trig,
    input logic          trig_pin
);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !arm) |=> trig);

    a_r7_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(samp_valid));

    a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !trig);

    a_r6_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
        arm ##1 (samp_valid && !arm) |=> !trig);

    a_r10_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_out_en |-> !trig_pin);

    a_r9_fast_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trig) && $past(fast_en && !fast_sel[FIW])) |-> $past(samp[fast_sel[FIW-1:0]]));

    a_r9_fast_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trig) && $past(fast_en && fast_sel[FIW])) |-> !$past(samp[fast_sel[FIW-1:0]]));
endmodule

bind qlut_trigger qlut_trigger_chk #(.CH(CH), .FIW(FAST_IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_valid  (samp_valid),
    .samp        (samp),
    .fast_en     (fast_en),
    .fast_sel    (fast_sel),
    .trig_out_en (trig_out_en),
    .arm         (arm),
    .trig        (trig),
    .trig_pin    (trig_pin)
);

// File: tb/sim_qlut_trigger.sv
`timescale 1ns/1ps
module sim_qlut_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_valid = 1'b0;
    logic [15:0] samp = '0;
    logic        cfg_row_we = 1'b0;
    logic [12:0] cfg_row_data = '0;
    logic        cfg_sel_we = 1'b0;
    logic [7:0]  cfg_sel = '0;
    logic        fast_en = 1'b0;
    logic [3:0]  fast_sel = '0;
    logic        trig_out_en = 1'b1;
    logic        arm = 1'b0;
    logic        trig, trig_pin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    qlut_trigger u0 (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp(samp),
        .cfg_row_we(cfg_row_we), .cfg_row_data(cfg_row_data),
        .cfg_sel_we(cfg_sel_we), .cfg_sel(cfg_sel),
        .fast_en(fast_en), .fast_sel(fast_sel), .trig_out_en(trig_out_en),
        .arm(arm), .trig(trig), .trig_pin(trig_pin)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_trig(input string req, input bit exp);
        check(trig === exp, req, {31'b0, trig}, {31'b0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk) begin samp_valid = 1'b1; samp = s; end
        @(negedge clk) samp_valid = 1'b0;
    endtask

    task automatic write_row(input logic [12:0] d, input logic [7:0] code);
        @(negedge clk) begin cfg_row_we = 1'b1; cfg_row_data = d; end
        @(negedge clk) begin cfg_row_we = 1'b0; cfg_sel_we = 1'b1; cfg_sel = code; end
        @(negedge clk) cfg_sel_we = 1'b0;
    endtask

    // entry r of group g for a value/mask pattern
    function automatic bit lut_bit(input int r, input int g, input logic [15:0] v, input logic [15:0] m);
        bit b = 1'b1;
        for (int k = 0; k < 4; k++)
            if (m[4*g+k] && (r[k] != v[4*g+k])) b = 1'b0;
        return b;
    endfunction

    function automatic logic [15:0] glue_for(input bit r0, input bit f0, input bit r1, input bit f1, input bit none);
        logic [15:0] gl;
        for (int i = 0; i < 16; i++) begin
            bit c0 = i[0], p0 = i[1], c1 = i[2], p1 = i[3];
            gl[i] = none || (r0 && c0 && !p0) || (f0 && !c0 && p0) ||
                    (r1 && c1 && !p1) || (f1 && !c1 && p1);
        end
        return gl;
    endfunction

    // R2 row layout: [3:0] value, [7:4] edge 0, [11:8] edge 1, [12] glue
    task automatic load(input logic [15:0] vv, input logic [15:0] vm,
                        input int p0, input int p1, input logic [15:0] glue);
        logic [15:0] m0, m1;
        m0 = (p0 < 0) ? 16'h0 : (16'h1 << p0);
        m1 = (p1 < 0) ? 16'h0 : (16'h1 << p1);
        for (int r = 0; r < 16; r++) begin
            logic [12:0] row;
            for (int g = 0; g < 4; g++) begin
                row[g]   = lut_bit(r, g, vv, vm);
                row[4+g] = lut_bit(r, g, m0, m0);
                row[8+g] = lut_bit(r, g, m1, m1);
            end
            row[12] = glue[r];
            write_row(row, 8'h30 | 8'(r));
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk_trig("R1 trig after reset", 1'b0);
        check(trig_pin === 1'b0, "R1 trig_pin after reset", {31'b0, trig_pin}, 0);
        push(16'hFFFF);
        push(16'h0000);
        chk_trig("R11 no trigger while idle", 1'b0);
        do_arm();
        push(16'h0000);
        push(16'hFFFF);
        push(16'h0000);
        chk_trig("R1 cleared tables never fire", 1'b0);
    endtask

    task automatic t_bad_select();
        for (int r = 0; r < 16; r++)
            write_row(13'h1FFF, 8'h20 | 8'(r));
        do_arm();
        push(16'h1234);
        push(16'h4321);
        chk_trig("R3 non-commit code writes nothing", 1'b0);
    endtask

    task automatic t_full_pattern();
        load(16'hA5C3, 16'hFFFF, -1, -1, glue_for(0, 0, 0, 0, 1));
        trig_out_en = 1'b1;
        do_arm();
        push(16'hA5C3);
        chk_trig("R6 priming sample does not fire", 1'b0);
        push(16'h1234);
        chk_trig("R4 mismatch does not fire", 1'b0);
        @(negedge clk) begin samp = 16'hA5C3; samp_valid = 1'b0; end
        @(negedge clk);
        chk_trig("R7 sample without valid ignored", 1'b0);
        push(16'hA5C3);
        chk_trig("R4 R2 full pattern fires", 1'b1);
        check(trig_pin === 1'b1, "R10 pin follows trig", {31'b0, trig_pin}, 1);
        push(16'h0000);
        push(16'h5555);
        chk_trig("R7 trigger stays high", 1'b1);
        do_arm();
        chk_trig("R8 arm clears trig", 1'b0);
    endtask

    task automatic t_partial_mask();
        load(16'h00F0, 16'h00F0, -1, -1, glue_for(0, 0, 0, 0, 1));
        do_arm();
        push(16'h0000);
        push(16'h12E4);
        chk_trig("R4 masked mismatch in group 1", 1'b0);
        push(16'h93F7);
        chk_trig("R4 unmasked bits are free", 1'b1);
    endtask

    task automatic t_edges();
        // rising on channel 5 via edge unit 0, falling on channel 9 via unit 1
        load(16'h0000, 16'h0000, 5, 9, glue_for(1, 0, 0, 1, 0));
        do_arm();
        push(16'h0020);
        push(16'h0020);
        chk_trig("R5 steady high is not an edge", 1'b0);
        push(16'h0000);
        chk_trig("R5 fall on rise-watched pin", 1'b0);
        push(16'h0020);
        chk_trig("R5 rising edge on unit 0 fires", 1'b1);
        do_arm();
        push(16'h0200);
        push(16'h0200);
        chk_trig("R5 steady level on unit 1", 1'b0);
        push(16'h0000);
        chk_trig("R5 falling edge on unit 1 fires", 1'b1);
        // value condition ANDed with edge: value needs channel 0 high
        load(16'h0001, 16'h0001, 5, -1, glue_for(1, 0, 0, 0, 0));
        do_arm();
        push(16'h0000);
        push(16'h0020);
        chk_trig("R5 edge without value match", 1'b0);
        push(16'h0001);
        push(16'h0021);
        chk_trig("R5 edge with value match fires", 1'b1);
    endtask

    task automatic t_fast();
        load(16'h0000, 16'hFFFF, -1, -1, 16'h0000);
        fast_en  = 1'b1;
        fast_sel = 4'b0011;
        trig_out_en = 1'b0;
        do_arm();
        push(16'h0000);
        push(16'hFFF7);
        chk_trig("R9 other pins ignored", 1'b0);
        push(16'h0008);
        chk_trig("R9 fast rising edge fires", 1'b1);
        check(trig_pin === 1'b0, "R10 pin disabled", {31'b0, trig_pin}, 0);
        fast_sel = 4'b1110;
        do_arm();
        push(16'h0000);
        push(16'h0040);
        chk_trig("R9 rise ignored in falling mode", 1'b0);
        push(16'h0000);
        chk_trig("R9 fast falling edge fires", 1'b1);
        fast_en = 1'b0;
        trig_out_en = 1'b1;
    endtask

    task automatic t_idle_after_reset();
        do_reset();
        fast_en  = 1'b1;
        fast_sel = 4'b0011;
        push(16'h0000);
        push(16'h0008);
        chk_trig("R11 idle ignores edges", 1'b0);
        fast_en = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_bad_select();
        t_full_pattern();
        t_partial_mask();
        t_edges();
        t_fast();
        t_idle_after_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule